// File: doc/BRIEF.md
# Instruction Operand Addressing Decoder

This block takes one 16-bit instruction word and turns both of its operand codes into resolved operand descriptions. An operand can resolve to a general register, a memory address, a literal value or one of the special registers (stack pointer, program counter, overflow register). While it resolves the operands, the block follows the program counter through any trailing operand words. It fetches those words over a one-cycle-latency memory read port. It also applies the stack-pointer changes that push and pop imply, and it counts the extra cycles spent on operand words. The execution stage that uses the operands is a separate unit.

A pulse on `start` loads the instruction word, the program counter (already pointing past the instruction word) and the stack pointer. The controller then walks through its states. IDLE waits for `start` (transition GO). A_DEC decodes the a operand. It either moves to A_WORD (FETCH_A) when a trailing word is needed, or resolves at once (RESOLVE_A). A_WORD completes the a operand from the fetched word. B_DEC and B_WORD do the same for the b operand (FETCH_B, RESOLVE_B). When the opcode field is zero, the controller goes from the a operand straight to DONE (SKIP_B). DONE raises `done` for one cycle and returns to IDLE (RETIRE). A general register is read through a combinational read port selected by `gpr_idx`.

Top module: `operand_decoder`

## Requirements
- R1: Field split: opcode is bits 4:0, b code is bits 9:5, a code is bits 15:10. The a operand is resolved before the b operand, so an a word is fetched at the loaded PC and a b word at the address after it.
- R2: Codes 0x00-0x07 give kind 0 (general register) with index equal to the code. Codes 0x08-0x0F give kind 1 (memory) with value equal to the content of register code-8. For memory and literal kinds the index output is 0.
- R3: Codes 0x10-0x17 give kind 1 with value = (word at PC) + register[code-0x10], modulo 2^16. PC advances by one and the extra-cycle count by one.
- R4: Code 0x18 in the b slot is a push: SP is decremented first and the value is the new SP. In the a slot it is a pop: the value is the old SP and SP is incremented afterwards. Both wrap modulo 2^16.
- R5: Code 0x19 gives kind 1 with value SP, and SP is unchanged. Code 0x1A gives kind 1 with value SP + (word at PC). PC advances by one, but no extra cycle is counted.
- R6: Codes 0x1B, 0x1C and 0x1D give kind 2 (special register) with index 0 (SP), 1 (PC) and 2 (EX).
- R7: Code 0x1E gives kind 1 with value equal to the word at PC. Code 0x1F gives kind 3 (literal) with value equal to the word at PC. Each advances PC by one and counts one extra cycle.
- R8: Codes 0x20-0x3F in the a slot give kind 3 with value code minus 0x21 modulo 2^16 (0x20 gives 0xFFFF, 0x3F gives 0x001E). No word is fetched and no extra cycle is counted.
- R9: When the opcode is zero, `ext_op` is 1 and `ext_sel` carries the b field unchanged. The b bundle stays at kind 0, index 0, value 0, writable 0, and the b field changes neither SP nor PC.
- R10: An operand's writable flag is 0 when its kind is 3 (literal) and 1 for every other kind, so a write-back to a literal is discarded.
- R11: After reset, `busy` and `done` are 0. `done` is a one-cycle pulse that appears at the third rising edge counting the one that samples `start`, one edge later per fetched word and one edge earlier when the opcode is zero. `start` is ignored while busy, and all results hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding `instr` (accepted only when idle) |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | PC pointing at the word after the instruction |
| sp_in | input | 16 | Stack pointer before the instruction |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle pulse: results valid |
| opcode | output | 5 | Latched opcode field |
| ext_op | output | 1 | Opcode field is zero |
| ext_sel | output | 5 | b field passed through for extended operations |
| gpr_idx | output | 3 | General register read select |
| gpr_rdata | input | 16 | Combinational general register read data |
| mem_rd_en | output | 1 | Operand word read request |
| mem_rd_addr | output | 16 | Operand word address (current PC) |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| a_kind | output | 2 | a operand kind: 0 register, 1 memory, 2 special, 3 literal |
| a_index | output | 3 | a register or special index |
| a_value | output | 16 | a address or literal value |
| a_wr_ok | output | 1 | a operand accepts write-back |
| b_kind | output | 2 | b operand kind |
| b_index | output | 3 | b register or special index |
| b_value | output | 16 | b address or literal value |
| b_wr_ok | output | 1 | b operand accepts write-back |
| pc_out | output | 16 | PC after operand words |
| sp_out | output | 16 | SP after push or pop |
| extra_cycles | output | 2 | Extra cycles spent on operand words |

## Verification
Two cases put two operand functions into one instruction. In the first, a pop in the a slot and a push in the b slot act on the stack pointer in the same instruction. The bench checks that the pop address is the loaded SP, that the push address equals that same value after the round trip, and that the final SP is unchanged. In the second, both slots carry a trailing word. The bench checks the a word is taken from the loaded PC and the b word from the next address, with PC advanced by two and both extra cycles counted. These expected values come from a bench-side memory function and register array.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int OPC_W   = 5;
    localparam int BCODE_W = 5;
    localparam int ACODE_W = 6;
    localparam int NGPR    = 8;
    localparam int GIDX_W  = $clog2(NGPR);
    localparam int LIT_BIAS = 'h21;

    typedef enum logic [1:0] {
        K_GPR  = 2'd0,
        K_MEM  = 2'd1,
        K_SPEC = 2'd2,
        K_LIT  = 2'd3
    } kind_e;

    typedef enum logic [3:0] {
        M_GPR, M_IND, M_IDX, M_STK, M_PEEK, M_PICK,
        M_SPEC, M_NWIND, M_NWLIT, M_INLIT
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  needs_word;
        logic  adds_cycle;
        logic  writable;
    } cls_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_A_DEC, ST_A_WORD, ST_B_DEC, ST_B_WORD, ST_DONE
    } state_e;

endpackage

// File: rtl/opdec_classify.sv
module opdec_classify
    import opdec_pkg::*;
(
    input  logic [ACODE_W-1:0] code,
    output cls_t               cls
);
    always_comb begin
        cls.mode       = M_GPR;
        cls.needs_word = 1'b0;
        cls.adds_cycle = 1'b0;
        cls.writable   = 1'b1;
        if (code[5]) begin
            cls.mode     = M_INLIT;
            cls.writable = 1'b0;
        end else begin
            unique case (code[4:3])
                2'b00: cls.mode = M_GPR;
                2'b01: cls.mode = M_IND;
                2'b10: begin
                    cls.mode       = M_IDX;
                    cls.needs_word = 1'b1;
                    cls.adds_cycle = 1'b1;
                end
                default: begin
                    unique case (code[2:0])
                        3'd0: cls.mode = M_STK;
                        3'd1: cls.mode = M_PEEK;
                        3'd2: begin
                            cls.mode       = M_PICK;
                            cls.needs_word = 1'b1;
                        end
                        3'd6: begin
                            cls.mode       = M_NWIND;
                            cls.needs_word = 1'b1;
                            cls.adds_cycle = 1'b1;
                        end
                        3'd7: begin
                            cls.mode       = M_NWLIT;
                            cls.needs_word = 1'b1;
                            cls.adds_cycle = 1'b1;
                            cls.writable   = 1'b0;
                        end
                        default: cls.mode = M_SPEC;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/opdec_resolve.sv
module opdec_resolve
    import opdec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  mode_e              mode,
    input  logic [ACODE_W-1:0] code,
    input  logic               is_b,
    input  logic [DATA_W-1:0]  gpr,
    input  logic [DATA_W-1:0]  sp,
    input  logic [DATA_W-1:0]  word,
    output kind_e              kind,
    output logic [GIDX_W-1:0]  index,
    output logic [DATA_W-1:0]  value,
    output logic [DATA_W-1:0]  sp_next
);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] BIAS = DATA_W'(LIT_BIAS);

    always_comb begin
        kind    = K_MEM;
        index   = '0;
        value   = '0;
        sp_next = sp;
        unique case (mode)
            M_GPR: begin
                kind  = K_GPR;
                index = code[GIDX_W-1:0];
            end
            M_IND:  value = gpr;
            M_IDX:  value = word + gpr;
            M_STK: begin
                if (is_b) begin
                    value   = sp - ONE;
                    sp_next = sp - ONE;
                end else begin
                    value   = sp;
                    sp_next = sp + ONE;
                end
            end
            M_PEEK:  value = sp;
            M_PICK:  value = sp + word;
            M_SPEC: begin
                kind  = K_SPEC;
                index = code[GIDX_W-1:0] - GIDX_W'(3);
            end
            M_NWIND: value = word;
            M_NWLIT: begin
                kind  = K_LIT;
                value = word;
            end
            M_INLIT: begin
                kind  = K_LIT;
                value = DATA_W'(code) - BIAS;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
    import opdec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DATA_W-1:0]    instr,
    input  logic [DATA_W-1:0]    pc_in,
    input  logic [DATA_W-1:0]    sp_in,
    output logic                 busy,
    output logic                 done,
    output logic [OPC_W-1:0]     opcode,
    output logic                 ext_op,
    output logic [BCODE_W-1:0]   ext_sel,
    output logic [GIDX_W-1:0]    gpr_idx,
    input  logic [DATA_W-1:0]    gpr_rdata,
    output logic                 mem_rd_en,
    output logic [DATA_W-1:0]    mem_rd_addr,
    input  logic [DATA_W-1:0]    mem_rd_data,
    output logic [1:0]           a_kind,
    output logic [GIDX_W-1:0]    a_index,
    output logic [DATA_W-1:0]    a_value,
    output logic                 a_wr_ok,
    output logic [1:0]           b_kind,
    output logic [GIDX_W-1:0]    b_index,
    output logic [DATA_W-1:0]    b_value,
    output logic                 b_wr_ok,
    output logic [DATA_W-1:0]    pc_out,
    output logic [DATA_W-1:0]    sp_out,
    output logic [1:0]           extra_cycles
);
    localparam int B_LO = OPC_W;
    localparam int A_LO = OPC_W + BCODE_W;

    state_e              state, state_nx;
    logic [DATA_W-1:0]   instr_q;
    logic                slot_b;
    logic [ACODE_W-1:0]  cur_code;
    cls_t                cls;
    kind_e               r_kind;
    logic [GIDX_W-1:0]   r_index;
    logic [DATA_W-1:0]   r_value;
    logic [DATA_W-1:0]   r_sp_next;
    logic                is_ext;

    assign slot_b   = (state == ST_B_DEC) || (state == ST_B_WORD);
    assign cur_code = slot_b ? {1'b0, instr_q[B_LO +: BCODE_W]}
                             : instr_q[A_LO +: ACODE_W];
    assign is_ext   = (instr_q[OPC_W-1:0] == '0);

    opdec_classify u_classify (
        .code (cur_code),
        .cls  (cls)
    );

    opdec_resolve #(.DATA_W(DATA_W)) u_resolve (
        .mode    (cls.mode),
        .code    (cur_code),
        .is_b    (slot_b),
        .gpr     (gpr_rdata),
        .sp      (sp_out),
        .word    (mem_rd_data),
        .kind    (r_kind),
        .index   (r_index),
        .value   (r_value),
        .sp_next (r_sp_next)
    );

    assign gpr_idx     = cur_code[GIDX_W-1:0];
    assign mem_rd_addr = pc_out;
    assign mem_rd_en   = ((state == ST_A_DEC) || (state == ST_B_DEC)) && cls.needs_word;
    assign busy        = (state != ST_IDLE);
    assign done        = (state == ST_DONE);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_A_DEC;                         // GO
            ST_A_DEC:  state_nx = cls.needs_word ? ST_A_WORD                    // FETCH_A
                                : (is_ext ? ST_DONE : ST_B_DEC);                // SKIP_B / RESOLVE_A
            ST_A_WORD: state_nx = is_ext ? ST_DONE : ST_B_DEC;
            ST_B_DEC:  state_nx = cls.needs_word ? ST_B_WORD : ST_DONE;         // FETCH_B / RESOLVE_B
            ST_B_WORD: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;                                      // RETIRE
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q      <= '0;
            opcode       <= '0;
            ext_op       <= 1'b0;
            ext_sel      <= '0;
            pc_out       <= '0;
            sp_out       <= '0;
            extra_cycles <= '0;
            a_kind <= '0; a_index <= '0; a_value <= '0; a_wr_ok <= 1'b0;
            b_kind <= '0; b_index <= '0; b_value <= '0; b_wr_ok <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        instr_q      <= instr;
                        opcode       <= instr[OPC_W-1:0];
                        ext_op       <= (instr[OPC_W-1:0] == '0);
                        ext_sel      <= instr[B_LO +: BCODE_W];
                        pc_out       <= pc_in;
                        sp_out       <= sp_in;
                        extra_cycles <= '0;
                        a_kind <= '0; a_index <= '0; a_value <= '0; a_wr_ok <= 1'b0;
                        b_kind <= '0; b_index <= '0; b_value <= '0; b_wr_ok <= 1'b0;
                    end
                end
                ST_A_DEC, ST_B_DEC: begin
                    if (cls.needs_word) begin
                        pc_out <= pc_out + DATA_W'(1);
                        if (cls.adds_cycle) extra_cycles <= extra_cycles + 2'd1;
                    end else begin
                        sp_out <= r_sp_next;
                        if (slot_b) begin
                            b_kind <= r_kind; b_index <= r_index;
                            b_value <= r_value; b_wr_ok <= cls.writable;
                        end else begin
                            a_kind <= r_kind; a_index <= r_index;
                            a_value <= r_value; a_wr_ok <= cls.writable;
                        end
                    end
                end
                ST_A_WORD, ST_B_WORD: begin
                    sp_out <= r_sp_next;
                    if (slot_b) begin
                        b_kind <= r_kind; b_index <= r_index;
                        b_value <= r_value; b_wr_ok <= cls.writable;
                    end else begin
                        a_kind <= r_kind; a_index <= r_index;
                        a_value <= r_value; a_wr_ok <= cls.writable;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3
    fetch_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (pc_out == $past(pc_out) + DATA_W'(1)));

    // R4
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((sp_out == $past(sp_out)) ||
                  (sp_out == $past(sp_out) + DATA_W'(1)) ||
                  (sp_out == $past(sp_out) - DATA_W'(1))));

    // R9
    ext_b_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ext_op) |-> (b_kind == 2'd0 && b_value == '0 && !b_wr_ok));

    // R10
    lit_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((a_wr_ok == (a_kind != 2'd3)) && (ext_op || (b_wr_ok == (b_kind != 2'd3)))));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pc_out) && $stable(sp_out) && $stable(a_value) && $stable(b_value)));

endmodule

// File: tb/test_operand_decoder.sv
module test_operand_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0, pc_in = '0, sp_in = '0;
    logic        busy, done, ext_op, mem_rd_en;
    logic [4:0]  opcode, ext_sel;
    logic [2:0]  gpr_idx, a_index, b_index;
    logic [15:0] gpr_rdata, mem_rd_addr, a_value, b_value, pc_out, sp_out;
    logic [15:0] mem_rd_data = '0;
    logic [1:0]  a_kind, b_kind, extra_cycles;
    logic        a_wr_ok, b_wr_ok;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] regs [8];

    always #4 clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    assign gpr_rdata = regs[gpr_idx];

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

    operand_decoder i_operand_decoder (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in), .sp_in(sp_in),
        .busy(busy), .done(done), .opcode(opcode), .ext_op(ext_op), .ext_sel(ext_sel),
        .gpr_idx(gpr_idx), .gpr_rdata(gpr_rdata), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .a_kind(a_kind), .a_index(a_index), .a_value(a_value), .a_wr_ok(a_wr_ok),
        .b_kind(b_kind), .b_index(b_index), .b_value(b_value), .b_wr_ok(b_wr_ok),
        .pc_out(pc_out), .sp_out(sp_out), .extra_cycles(extra_cycles)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int b, input int a);
        return {a[5:0], b[4:0], op[4:0]};
    endfunction

    task automatic run(input logic [15:0] ins, input logic [15:0] pc, input logic [15:0] sp,
                       output int n);
        @(negedge clk);
        instr = ins; pc_in = pc; sp_in = sp; start = 1'b1;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
        end
    endtask

    task automatic t_reset;
        chk("R11 busy after reset", busy, 0);
        chk("R11 done after reset", done, 0);
    endtask

    task automatic t_registers;
        int n;
        run(enc(1, 5, 'h0B), 16'h0030, 16'h0500, n);
        chk("R11 latency plain", n, 3);
        chk("R1 opcode", opcode, 1);
        chk("R2 a kind indirect", a_kind, 1);
        chk("R2 a value indirect", a_value, regs[3]);
        chk("R2 a index", a_index, 0);
        chk("R2 b kind reg", b_kind, 0);
        chk("R2 b index reg", b_index, 5);
        chk("R10 a wr_ok", a_wr_ok, 1);
        chk("R10 b wr_ok", b_wr_ok, 1);
        chk("R2 pc unchanged", pc_out, 16'h0030);
        chk("R2 extra zero", extra_cycles, 0);
        run(enc(2, 'h1B, 'h1C), 16'h0030, 16'h0500, n);
        chk("R6 a kind", a_kind, 2);
        chk("R6 a index PC", a_index, 1);
        chk("R6 b index SP", b_index, 0);
        run(enc(2, 'h1D, 'h07), 16'h0030, 16'h0500, n);
        chk("R6 b index EX", b_index, 2);
        chk("R2 a index r7", a_index, 7);
    endtask

    task automatic t_two_words;
        int n;
        run(enc(3, 'h1E, 'h13), 16'h0040, 16'h0500, n);
        chk("R11 latency two words", n, 5);
        chk("R3 a value indexed", a_value, 16'(memf(16'h0040) + regs[3]));
        chk("R1 b word after a word", b_value, memf(16'h0041));
        chk("R7 b kind", b_kind, 1);
        chk("R3 pc advanced twice", pc_out, 16'h0042);
        chk("R3 extra two", extra_cycles, 2);
    endtask

    task automatic t_word_literal;
        int n;
        run(enc(4, 'h1F, 'h1F), 16'hFFFF, 16'h0500, n);
        chk("R7 a kind literal", a_kind, 3);
        chk("R7 a value", a_value, memf(16'hFFFF));
        chk("R7 b value wrapped pc", b_value, memf(16'h0000));
        chk("R10 b literal not writable", b_wr_ok, 0);
        chk("R7 pc wrap", pc_out, 16'h0001);
    endtask

    task automatic t_stack;
        int n;
        run(enc(1, 'h18, 'h18), 16'h0010, 16'h0100, n);
        chk("R4 pop addr", a_value, 16'h0100);
        chk("R4 push addr", b_value, 16'h0100);
        chk("R4 sp net", sp_out, 16'h0100);
        run(enc(1, 'h01, 'h18), 16'h0010, 16'hFFFF, n);
        chk("R4 pop at top", a_value, 16'hFFFF);
        chk("R4 pop wraps sp", sp_out, 16'h0000);
        run(enc(1, 'h18, 'h00), 16'h0010, 16'h0000, n);
        chk("R4 push wraps addr", b_value, 16'hFFFF);
        chk("R4 push wraps sp", sp_out, 16'hFFFF);
    endtask

    task automatic t_peek_pick;
        int n;
        run(enc(5, 'h19, 'h1A), 16'h0010, 16'h0200, n);
        chk("R5 pick value", a_value, 16'(16'h0200 + memf(16'h0010)));
        chk("R5 peek value", b_value, 16'h0200);
        chk("R5 sp kept", sp_out, 16'h0200);
        chk("R5 pc advanced", pc_out, 16'h0011);
        chk("R5 pick no extra", extra_cycles, 0);
        chk("R11 latency one word", n, 4);
    endtask

    task automatic t_inline;
        int n;
        run(enc(6, 'h00, 'h20), 16'h0020, 16'h0300, n);
        chk("R8 code 0x20", a_value, 16'hFFFF);
        chk("R8 kind", a_kind, 3);
        chk("R10 inline not writable", a_wr_ok, 0);
        chk("R8 no fetch", pc_out, 16'h0020);
        chk("R8 no extra", extra_cycles, 0);
        run(enc(6, 'h00, 'h21), 16'h0020, 16'h0300, n);
        chk("R8 code 0x21", a_value, 0);
        run(enc(6, 'h00, 'h3F), 16'h0020, 16'h0300, n);
        chk("R8 code 0x3F", a_value, 16'h001E);
    endtask

    task automatic t_ext;
        int n;
        run(enc(0, 'h18, 'h1F), 16'h0050, 16'h0400, n);
        chk("R9 latency", n, 3);
        chk("R9 ext_op", ext_op, 1);
        chk("R9 ext_sel", ext_sel, 'h18);
        chk("R9 sp untouched", sp_out, 16'h0400);
        chk("R9 pc one word", pc_out, 16'h0051);
        chk("R9 b kind", b_kind, 0);
        chk("R9 b value", b_value, 0);
        chk("R9 b wr_ok", b_wr_ok, 0);
        chk("R9 a literal", a_value, memf(16'h0050));
    endtask

    task automatic t_start_ignored;
        int n;
        @(negedge clk);
        instr = enc(1, 'h02, 'h09); pc_in = 16'h0070; sp_in = 16'h0600; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr = enc(1, 'h18, 'h1E); pc_in = 16'h0900; sp_in = 16'h0900;
        n = 1;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
        end
        chk("R11 busy start ignored a", a_value, regs[1]);
        chk("R11 busy start ignored sp", sp_out, 16'h0600);
        chk("R11 latency with ignored start", n, 3);
        repeat (3) @(negedge clk);
        chk("R11 hold done low", done, 0);
        chk("R11 hold a", a_value, regs[1]);
        chk("R11 hold pc", pc_out, 16'h0070);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 16'(16'h1000 + i * 16'h0111);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_registers();
        t_two_words();
        t_word_literal();
        t_stack();
        t_peek_pick();
        t_inline();
        t_ext();
        t_start_ignored();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule